// File: doc/BRIEF.md
# Operand-Size-Aware 64-bit Register File

This block is a general-purpose register file with sixteen 64-bit entries. It has two combinational read ports and one synchronous write port. The write port merges each result into the old register contents according to a 2-bit operand-size code. A 32-bit result clears the upper half of the register. An 8-bit or 16-bit result replaces only its own low slice and keeps the other bits. A 64-bit result replaces the whole register.

A combinational operand-formation path sits beside the storage. It sign-extends 32-bit immediates and 32-bit displacements to 64 bits, passes a full 64-bit immediate through for a 64-bit move, and limits shift counts to the operand size.

A mode input (`mode64`) tells the block whether it is in 64-bit mode. Each register carries a flag that marks its upper half as undefined. Any clock edge seen with `mode64` low sets the flag on every register. After the block returns to 64-bit mode, a flagged register reads back with a fixed poison pattern in its upper half until a 32-bit or 64-bit write defines that half again.

Top module: `gpr64_file`

## Requirements
- R1: After synchronous active-high reset, every register reads as zero on both ports, and in 64-bit mode `rd_upper_ok_*` is 1.
- R2: In 64-bit mode, a write with size code 2'b11 replaces all 64 bits of the destination and clears its undefined flag.
- R3: In 64-bit mode, a write with size code 2'b10 stores the low 32 data bits, sets bits 63:32 to zero and clears the undefined flag.
- R4: A write with size code 2'b00 replaces bits 7:0 only; bits 63:8 keep their old value.
- R5: A write with size code 2'b01 replaces bits 15:0 only; bits 63:16 keep their old value.
- R6: A read of a register in the same cycle as a write to it returns the value from before the write. There is no bypass.
- R7: The two read ports are independent: each returns the register that its own address selects in the same cycle.
- R8: A clock edge with `mode64` low marks every register's upper half as undefined. Back in 64-bit mode, such a register reads with bits 63:32 equal to 32'hBAD0_BAD0 and with `rd_upper_ok_*` equal to 0.
- R9: While `mode64` is low, reads return bits 63:32 as zero and `rd_upper_ok_*` as 0. In this mode, size codes 2'b10 and 2'b11 both store the low 32 bits.
- R10: An 8-bit or 16-bit write does not clear a register's undefined flag.
- R11: The immediate output works as follows:
  - Size 2'b11 sign-extends the 32-bit immediate.
  - Size 2'b11 with `opf_mov_full` high passes the 64-bit immediate unchanged.
  - Sizes 2'b10, 2'b01 and 2'b00 give the immediate truncated to 32, 16 or 8 bits and zero-extended.
- R12: The displacement output is always the 32-bit displacement sign-extended to 64 bits.
- R13: The shift-count output is the 6-bit input unchanged for size 2'b11. For any other size, bit 5 is forced to zero.
- R14: With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | High while in 64-bit mode |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Destination register |
| wr_size | input | 2 | Operand size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| wr_data | input | 64 | Result to merge |
| rd_addr_a | input | 4 | Read port A address |
| rd_data_a | output | 64 | Read port A data |
| rd_upper_ok_a | output | 1 | Port A upper half is defined |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | 64 | Read port B data |
| rd_upper_ok_b | output | 1 | Port B upper half is defined |
| opf_size | input | 2 | Operand size for the operand-formation path |
| opf_mov_full | input | 1 | Instruction is a move with a full 64-bit immediate |
| opf_imm | input | 32 | Encoded immediate |
| opf_imm_full | input | 64 | Full-width move immediate |
| opf_imm_out | output | 64 | Formed immediate operand |
| opf_disp | input | 32 | Encoded displacement |
| opf_disp_out | output | 64 | Sign-extended displacement |
| opf_count_in | input | 6 | Raw shift or rotate count |
| opf_count_out | output | 6 | Size-limited count |

## Verification
Two pairs of functions can land in the same clock cycle.

The first pair is a write and a read of the same register. The bench drives a write and points a read port at the destination in the same cycle. It expects the old contents before the edge and the merged value after it.

The second pair is a partial-width merge and the undefined-upper marking. The bench leaves 64-bit mode, returns, and then issues an 8-bit write to a flagged register. It checks that the upper half still reads as poison. A following 32-bit write must make the upper half defined again, reading as zero.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_D = 2'b11
  } opsize_e;

  localparam int BYTE_W = 8;
  localparam int HWORD_W = 16;
endpackage

// File: rtl/gpr_write_merge.sv
// Merges an incoming result into the old register value by operand size.
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic            long_mode,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_val,
  output logic [XLEN-1:0] merged,
  output logic            defines_upper
);
  localparam int HALF = XLEN / 2;

  opsize_e sz;
  assign sz = opsize_e'(size);

  always_comb begin
    merged        = old_val;
    defines_upper = 1'b0;
    unique case (sz)
      SZ_B: merged[BYTE_W-1:0]  = new_val[BYTE_W-1:0];
      SZ_H: merged[HWORD_W-1:0] = new_val[HWORD_W-1:0];
      SZ_W: begin
        merged        = {{HALF{1'b0}}, new_val[HALF-1:0]};
        defines_upper = long_mode;
      end
      SZ_D: begin
        // Outside 64-bit mode the widest size behaves as 32-bit.
        merged        = long_mode ? new_val : {{HALF{1'b0}}, new_val[HALF-1:0]};
        defines_upper = long_mode;
      end
      default: merged = old_val;
    endcase
  end
endmodule

// File: rtl/gpr_upper_track.sv
// One flag per register: set means the upper half is undefined.
module gpr_upper_track #(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode64,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic            defines_upper,
  output logic [NREG-1:0] undef
);
  for (genvar i = 0; i < NREG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        undef[i] <= 1'b0;
      end else if (!mode64) begin
        undef[i] <= 1'b1;
      end else if (wr_en && wr_addr == AW'(i) && defines_upper) begin
        undef[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpr_bank.sv
// Storage array: one write port, NRD asynchronous read ports.
module gpr_bank #(
  parameter int NREG = 16,
  parameter int XLEN = 64,
  parameter int NRD  = 3,
  localparam int AW = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata[k] = mem[raddr[k]];
  end
endmodule

// File: rtl/gpr_read_port.sv
// Applies mode and undefined-upper handling to a raw register value.
module gpr_read_port #(
  parameter int XLEN = 64,
  parameter logic [XLEN/2-1:0] POISON = 32'hBAD0_BAD0
) (
  input  logic            mode64,
  input  logic            undef,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] data,
  output logic            upper_ok
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    if (!mode64) begin
      data     = {{HALF{1'b0}}, raw[HALF-1:0]};
      upper_ok = 1'b0;
    end else if (undef) begin
      data     = {POISON, raw[HALF-1:0]};
      upper_ok = 1'b0;
    end else begin
      data     = raw;
      upper_ok = 1'b1;
    end
  end
endmodule

// File: rtl/gpr_operand_form.sv
// Immediate, displacement and shift-count formation.
module gpr_operand_form
  import gpr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [1:0]      size,
  input  logic            mov_full,
  input  logic [IMMW-1:0] imm,
  input  logic [XLEN-1:0] imm_full,
  input  logic [IMMW-1:0] disp,
  input  logic [SHW-1:0]  count_in,
  output logic [XLEN-1:0] imm_out,
  output logic [XLEN-1:0] disp_out,
  output logic [SHW-1:0]  count_out
);
  opsize_e sz;
  assign sz = opsize_e'(size);

  always_comb begin
    unique case (sz)
      SZ_B: imm_out = {{(XLEN-BYTE_W){1'b0}}, imm[BYTE_W-1:0]};
      SZ_H: imm_out = {{(XLEN-HWORD_W){1'b0}}, imm[HWORD_W-1:0]};
      SZ_W: imm_out = {{(XLEN-IMMW){1'b0}}, imm};
      SZ_D: imm_out = mov_full ? imm_full : {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
      default: imm_out = '0;
    endcase
  end

  assign disp_out  = {{(XLEN-IMMW){disp[IMMW-1]}}, disp};
  assign count_out = (sz == SZ_D) ? count_in : {1'b0, count_in[SHW-2:0]};
endmodule

// File: rtl/gpr64_file.sv
module gpr64_file #(
  parameter int NREG = 16,
  parameter int XLEN = 64,
  parameter int IMMW = 32,
  parameter logic [XLEN/2-1:0] POISON = 32'hBAD0_BAD0,
  localparam int AW  = $clog2(NREG),
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode64,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_size,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  output logic            rd_upper_ok_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  output logic            rd_upper_ok_b,
  input  logic [1:0]      opf_size,
  input  logic            opf_mov_full,
  input  logic [IMMW-1:0] opf_imm,
  input  logic [XLEN-1:0] opf_imm_full,
  output logic [XLEN-1:0] opf_imm_out,
  input  logic [IMMW-1:0] opf_disp,
  output logic [XLEN-1:0] opf_disp_out,
  input  logic [SHW-1:0]  opf_count_in,
  output logic [SHW-1:0]  opf_count_out
);
  localparam int NUSR = 2;
  localparam int NRD  = NUSR + 1;   // plus the merge read of the destination

  logic [NRD-1:0][AW-1:0]   raddr;
  logic [NRD-1:0][XLEN-1:0] rraw;
  logic [NREG-1:0]          undef;
  logic [XLEN-1:0]          merged;
  logic                     defines_upper;
  logic [NUSR-1:0][XLEN-1:0] pdata;
  logic [NUSR-1:0]           pok;

  assign raddr[0] = rd_addr_a;
  assign raddr[1] = rd_addr_b;
  assign raddr[2] = wr_addr;

  gpr_bank #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (merged),
    .raddr (raddr),
    .rdata (rraw)
  );

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .size          (wr_size),
    .long_mode     (mode64),
    .old_val       (rraw[NUSR]),
    .new_val       (wr_data),
    .merged        (merged),
    .defines_upper (defines_upper)
  );

  gpr_upper_track #(.NREG(NREG)) u_track (
    .clk           (clk),
    .rst           (rst),
    .mode64        (mode64),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .defines_upper (defines_upper),
    .undef         (undef)
  );

  for (genvar p = 0; p < NUSR; p++) begin : g_port
    gpr_read_port #(.XLEN(XLEN), .POISON(POISON)) u_port (
      .mode64   (mode64),
      .undef    (undef[raddr[p]]),
      .raw      (rraw[p]),
      .data     (pdata[p]),
      .upper_ok (pok[p])
    );
  end

  assign rd_data_a     = pdata[0];
  assign rd_upper_ok_a = pok[0];
  assign rd_data_b     = pdata[1];
  assign rd_upper_ok_b = pok[1];

  gpr_operand_form #(.XLEN(XLEN), .IMMW(IMMW)) u_opf (
    .size      (opf_size),
    .mov_full  (opf_mov_full),
    .imm       (opf_imm),
    .imm_full  (opf_imm_full),
    .disp      (opf_disp),
    .count_in  (opf_count_in),
    .imm_out   (opf_imm_out),
    .disp_out  (opf_disp_out),
    .count_out (opf_count_out)
  );
endmodule

// File: rtl/gpr64_file_chk.sv
module gpr64_file_chk #(
  parameter int XLEN = 64,
  parameter int IMMW = 32,
  parameter int AW   = 4,
  parameter int SHW  = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            mode64,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [1:0]      wr_size,
  input logic [XLEN-1:0] wr_data,
  input logic [AW-1:0]   rd_addr_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic            rd_upper_ok_a,
  input logic [1:0]      opf_size,
  input logic [IMMW-1:0] opf_disp,
  input logic [XLEN-1:0] opf_disp_out,
  input logic [SHW-1:0]  opf_count_out
);
  localparam int HALF = XLEN / 2;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && mode64) |-> (rd_data_a == '0 && rd_upper_ok_a));

  assert_full_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b11 && mode64) |=>
      (rd_addr_a != $past(wr_addr) || !mode64 ||
       (rd_data_a == $past(wr_data) && rd_upper_ok_a)));

  assert_word_zext_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b10 && mode64) |=>
      (rd_addr_a != $past(wr_addr) || !mode64 ||
       (rd_data_a == {{HALF{1'b0}}, $past(wr_data[HALF-1:0])} && rd_upper_ok_a)));

  assert_byte_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00 && mode64 && rd_addr_a == wr_addr) |=>
      (rd_addr_a != $past(rd_addr_a) || !mode64 ||
       rd_data_a == {$past(rd_data_a[XLEN-1:8]), $past(wr_data[7:0])}));

  assert_legacy_upper_R9: assert property (@(posedge clk) disable iff (rst)
    !mode64 |-> (rd_data_a[XLEN-1:HALF] == '0 && !rd_upper_ok_a));

  assert_disp_sext_R12: assert property (@(posedge clk) disable iff (rst)
    opf_disp_out[XLEN-1:IMMW] == {(XLEN-IMMW){opf_disp[IMMW-1]}});

  assert_count_mask_R13: assert property (@(posedge clk) disable iff (rst)
    (opf_size != 2'b11) |-> !opf_count_out[SHW-1]);
endmodule

bind gpr64_file gpr64_file_chk #(.XLEN(XLEN), .IMMW(IMMW), .AW(AW), .SHW(SHW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode64        (mode64),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_size       (wr_size),
  .wr_data       (wr_data),
  .rd_addr_a     (rd_addr_a),
  .rd_data_a     (rd_data_a),
  .rd_upper_ok_a (rd_upper_ok_a),
  .opf_size      (opf_size),
  .opf_disp      (opf_disp),
  .opf_disp_out  (opf_disp_out),
  .opf_count_out (opf_count_out)
);

// File: tb/gpr64_file_bench.sv
`timescale 1ns/1ps
module gpr64_file_bench;
  localparam logic [31:0] POISON = 32'hBAD0_BAD0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode64 = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [1:0] wr_size = '0;
  logic [63:0] wr_data = '0;
  logic [3:0] rd_addr_a = '0, rd_addr_b = '0;
  logic [63:0] rd_data_a, rd_data_b;
  logic rd_upper_ok_a, rd_upper_ok_b;
  logic [1:0] opf_size = 2'b11;
  logic opf_mov_full = 1'b0;
  logic [31:0] opf_imm = '0, opf_disp = '0;
  logic [63:0] opf_imm_full = '0;
  logic [63:0] opf_imm_out, opf_disp_out;
  logic [5:0] opf_count_in = '0, opf_count_out;

  always #10 clk = ~clk;

  gpr64_file u_gpr64_file (.*);

  typedef struct {
    int kind;          // 0 data_a, 1 ok_a, 2 data_b, 3 ok_b, 4 imm, 5 disp, 6 count
    logic [63:0] exp;
    string req;
    int cyc;
  } sb_item_t;

  sb_item_t sb[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] mdl [16];
  bit mflag [16];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc == cyc) begin
      sb_item_t it;
      logic [63:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = rd_data_a;
        1: act = {63'd0, rd_upper_ok_a};
        2: act = rd_data_b;
        3: act = {63'd0, rd_upper_ok_b};
        4: act = opf_imm_out;
        5: act = opf_disp_out;
        default: act = {58'd0, opf_count_out};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic [63:0] exp_rd(input int a);
    if (!mode64) return {32'd0, mdl[a][31:0]};
    if (mflag[a]) return {POISON, mdl[a][31:0]};
    return mdl[a];
  endfunction

  task automatic push(input int kind, input logic [63:0] e, input string req);
    sb_item_t it;
    it.kind = kind; it.exp = e; it.req = req; it.cyc = cyc;
    sb.push_back(it);
  endtask

  task automatic push_rd(input int port, input int a, input string req);
    push(port * 2, exp_rd(a), req);
    push(port * 2 + 1, {63'd0, mode64 && !mflag[a]}, req);
  endtask

  // one cycle: reads at a and b, optional write
  task automatic step(input bit we, input int wa, input logic [1:0] sz, input logic [63:0] d,
                      input int ra, input int rb, input string req);
    wr_en = we; wr_addr = 4'(wa); wr_size = sz; wr_data = d;
    rd_addr_a = 4'(ra); rd_addr_b = 4'(rb);
    #0;
    push_rd(0, ra, req);
    push_rd(1, rb, req);
    @(posedge clk);
    if (!mode64) for (int i = 0; i < 16; i++) mflag[i] = 1;
    if (we) begin
      case (sz)
        2'b00: mdl[wa] = {mdl[wa][63:8], d[7:0]};
        2'b01: mdl[wa] = {mdl[wa][63:16], d[15:0]};
        2'b10: begin mdl[wa] = {32'd0, d[31:0]}; if (mode64) mflag[wa] = 0; end
        default: begin
          mdl[wa] = mode64 ? d : {32'd0, d[31:0]};
          if (mode64) mflag[wa] = 0;
        end
      endcase
    end
    #1;
    wr_en = 0;
  endtask

  task automatic opf(input logic [1:0] sz, input bit mf, input logic [31:0] imm,
                     input logic [63:0] full, input logic [31:0] disp, input logic [5:0] cnt,
                     input logic [63:0] e_imm, input logic [63:0] e_disp, input logic [5:0] e_cnt,
                     input string req);
    opf_size = sz; opf_mov_full = mf; opf_imm = imm; opf_imm_full = full;
    opf_disp = disp; opf_count_in = cnt;
    push(4, e_imm, req);
    push(5, e_disp, req);
    push(6, {58'd0, e_cnt}, req);
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mdl[i] = '0; mflag[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    step(0, 0, 2'b11, 64'h0, 0, 5, "R1");
    step(0, 0, 2'b11, 64'h0, 15, 3, "R1");
    // R2 full write, then read
    step(1, 3, 2'b11, 64'h1122334455667788, 0, 1, "R2");
    step(0, 0, 2'b11, 64'h0, 3, 3, "R2");
    // R4 byte merge
    step(1, 3, 2'b00, 64'hFFFFFFFFFFFFFFAA, 3, 0, "R4");
    step(0, 0, 2'b11, 64'h0, 3, 0, "R4");
    // R5 half-word merge
    step(1, 3, 2'b01, 64'hFFFFFFFFFFFFBEEF, 0, 0, "R5");
    step(0, 0, 2'b11, 64'h0, 3, 0, "R5");
    // R3 word write zero-extends
    step(1, 3, 2'b10, 64'hAAAAAAAACAFEF00D, 0, 0, "R3");
    step(0, 0, 2'b11, 64'h0, 3, 0, "R3");
    // R6 same-cycle read returns old value, R7 ports independent
    step(1, 7, 2'b11, 64'h0123456789ABCDEF, 7, 7, "R6");
    step(0, 0, 2'b11, 64'h0, 3, 7, "R7");
    step(0, 0, 2'b11, 64'h0, 7, 3, "R7");
    // R14 write disabled
    step(0, 7, 2'b11, 64'hDEADDEADDEADDEAD, 7, 0, "R14");
    step(0, 0, 2'b11, 64'h0, 7, 0, "R14");
    // leave 64-bit mode: R9
    step(1, 9, 2'b11, 64'hFEDCBA9876543210, 0, 0, "R9");
    mode64 = 0;
    step(1, 10, 2'b11, 64'h5555555512345678, 9, 10, "R9");
    step(0, 0, 2'b11, 64'h0, 9, 10, "R9");
    mode64 = 1;
    // R8 poison upper after return
    step(0, 0, 2'b11, 64'h0, 9, 3, "R8");
    // R10 byte write keeps undefined flag
    step(1, 9, 2'b00, 64'h00000000000000C3, 0, 0, "R10");
    step(0, 0, 2'b11, 64'h0, 9, 0, "R10");
    // R3 word write defines upper again
    step(1, 9, 2'b10, 64'h7777777700000042, 0, 0, "R3");
    step(0, 0, 2'b11, 64'h0, 9, 10, "R3");
    // R2 full write clears flag
    step(1, 10, 2'b11, 64'h8000000000000001, 0, 0, "R2");
    step(0, 0, 2'b11, 64'h0, 10, 9, "R2");
    // operand formation: R11, R12, R13
    opf(2'b11, 0, 32'h80000001, 64'h0, 32'h80000000, 6'h3F,
        64'hFFFFFFFF80000001, 64'hFFFFFFFF80000000, 6'h3F, "R11");
    opf(2'b11, 1, 32'h80000001, 64'hCAFEBABE12345678, 32'h7FFFFFFF, 6'h21,
        64'hCAFEBABE12345678, 64'h000000007FFFFFFF, 6'h21, "R11");
    opf(2'b10, 0, 32'h80000001, 64'h0, 32'hFFFFFFF0, 6'h3F,
        64'h0000000080000001, 64'hFFFFFFFFFFFFFFF0, 6'h1F, "R13");
    opf(2'b01, 1, 32'h8000F0F1, 64'hCAFEBABE12345678, 32'h00000010, 6'h25,
        64'h000000000000F0F1, 64'h0000000000000010, 6'h05, "R11");
    opf(2'b00, 0, 32'hFFFFFF81, 64'h0, 32'h80000001, 6'h20,
        64'h0000000000000081, 64'hFFFFFFFF80000001, 6'h00, "R12");
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule